// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous host and one external byte-wide asynchronous static RAM of 512K locations. The host raises a request with a 19-bit location, a write byte and a direction flag. The controller then runs one complete memory access and answers with a single-cycle acknowledge. For reads, the byte that was fetched appears on a held data register, and a valid flag pulses together with the acknowledge.

The memory pins are driven from registers. These are the active-low chip select, output enable and write strobe, the address, and a data bus split into outgoing byte, incoming byte and driver enable. Each phase of an access lasts a whole number of clock cycles. The count is taken from the memory's timing limits (in picoseconds) and the clock period, both given as parameters. A write is framed as the overlap of chip select and write strobe. The data driver turns on only after the write strobe is already low, and it stays on for one cycle after the strobe rises.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, with no request, chip select, output enable and write strobe are high (1), the data driver enable is 0, and acknowledge and read-valid are 0.
- R2: A read accepted at a clock edge drives chip select and output enable low, with the write strobe high, for exactly RD_CYC cycles from the next cycle. RD_CYC = max(1, ceil(access time / clock period), ceil(cycle time / clock period)).
- R3: A read samples the incoming byte at the edge that ends its last low cycle. In the following cycle it raises acknowledge and read-valid for one cycle, and the read data output holds that byte, which is the byte last written to that location.
- R4: A write accepted at a clock edge gives one cycle with chip select low and write strobe high, then WP_CYC cycles with both low, with output enable high throughout. WP_CYC = max(ceil(strobe width / period), ceil(data setup / period) + 1, ceil(address setup / period), ceil(cycle time / period) - 1).
- R5: The data driver enable is 0 in the setup cycle and in the first strobe-low cycle. It is 1 for the remaining strobe-low cycles and for the one cycle after the strobe rises, then 0 again. While it is 1, the outgoing byte equals the write byte.
- R6: A write raises acknowledge for exactly one cycle, in the cycle after the write strobe rises. Read-valid stays 0 for writes.
- R7: A request is taken only while the controller is idle. A request held high through an acknowledge starts the next access no earlier than two cycles after the acknowledge cycle.
- R8: After every access, chip select stays high for at least two cycles before it falls again.
- R9: The memory address equals the host address present when the request was taken, and it stays constant while chip select is low. Host address, byte or direction changes after acceptance have no effect on that access.
- R10: The write strobe and the output enable are never low in the same cycle, and the data driver is never enabled while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req_i | input | 1 | Access request, sampled only when idle |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 19 | Location of the access |
| host_wdata_i | input | 8 | Byte to write |
| host_ack_o | output | 1 | One-cycle completion pulse |
| host_rdata_o | output | 8 | Last byte read |
| host_rvalid_o | output | 1 | Read data valid pulse, with acknowledge |
| mem_addr_o | output | 19 | Memory address |
| mem_ce_n_o | output | 1 | Memory chip select, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write strobe, active low |
| mem_dq_o | output | 8 | Byte driven toward the memory |
| mem_dq_i | input | 8 | Byte returned by the memory |
| mem_dq_oe_o | output | 1 | Enable of the controller's data driver |

## Verification
Two things coincide when a request stays high through an acknowledge. The completion of one access (the acknowledge, the read capture or the end of the data drive) falls in the same cycle that presents the next request, and that request carries new fields. The bench provokes this with a write followed at once by a read of the same location, and with host fields changed right after acceptance. A behavioural reference model predicts every pin in every cycle and judges the result: the second access must start only after the recovery cycle, and it must return the byte the first access wrote. A memory stub also counts strobe widths and data setup.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSETUP,
        ST_WPULSE,
        ST_RECOVER
    } ctrl_state_e;

    // Whole cycles covering a time, never less than one.
    function automatic int unsigned cyc_of(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_latch.sv
module sram_rd_latch #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);
    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic              rvalid_d, rvalid_q;

    always_comb begin
        rdata_d  = capture_i ? din_i : rdata_q;
        rvalid_d = capture_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rdata_q  <= rdata_d;
            rvalid_q <= rvalid_d;
        end
    end

    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_PS    = 10000,
    parameter int unsigned T_ACC_PS  = 10000,
    parameter int unsigned T_CYC_PS  = 10000,
    parameter int unsigned T_WPW_PS  = 7000,
    parameter int unsigned T_DSU_PS  = 6000,
    parameter int unsigned T_ASU_PS  = 7000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req_i,
    input  logic              host_we_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic              host_ack_o,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic              host_rvalid_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_ce_n_o,
    output logic              mem_oe_n_o,
    output logic              mem_we_n_o,
    output logic [DATA_W-1:0] mem_dq_o,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_dq_oe_o
);
    // Strobe-low length of a read and of the write pulse, in cycles.
    localparam int unsigned RD_CYC = umax(cyc_of(T_ACC_PS, CLK_PS), cyc_of(T_CYC_PS, CLK_PS));
    localparam int unsigned WP_CYC = umax(umax(cyc_of(T_WPW_PS, CLK_PS), cyc_of(T_DSU_PS, CLK_PS) + 1),
                                          umax(cyc_of(T_ASU_PS, CLK_PS), cyc_of(T_CYC_PS, CLK_PS) - 1));
    localparam int unsigned CNT_W  = $clog2(umax(RD_CYC, WP_CYC) + 1);

    typedef struct packed {
        ctrl_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic              ack;
    } ctrl_regs_t;

    ctrl_regs_t        r_d, r_q;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_zero;
    logic              rd_capture;

    always_comb begin
        r_d        = r_q;
        r_d.ack    = 1'b0;
        cnt_load   = 1'b0;
        cnt_val    = '0;
        rd_capture = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (host_req_i) begin
                    r_d.addr  = host_addr_i;
                    r_d.wdata = host_wdata_i;
                    r_d.ce_n  = 1'b0;
                    if (host_we_i) begin
                        r_d.state = ST_WSETUP;
                    end else begin
                        r_d.state = ST_READ;
                        r_d.oe_n  = 1'b0;
                        cnt_load  = 1'b1;
                        cnt_val   = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (cnt_zero) begin
                    rd_capture = 1'b1;
                    r_d.ce_n   = 1'b1;
                    r_d.oe_n   = 1'b1;
                    r_d.ack    = 1'b1;
                    r_d.state  = ST_RECOVER;
                end
            end
            ST_WSETUP: begin
                r_d.we_n  = 1'b0;
                r_d.state = ST_WPULSE;
                cnt_load  = 1'b1;
                cnt_val   = CNT_W'(WP_CYC - 1);
            end
            ST_WPULSE: begin
                // Driver turns on only once the strobe is already low.
                r_d.dq_oe = 1'b1;
                if (cnt_zero) begin
                    r_d.we_n  = 1'b1;
                    r_d.ce_n  = 1'b1;
                    r_d.ack   = 1'b1;
                    r_d.state = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                r_d.dq_oe = 1'b0;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.addr  <= '0;
            r_q.wdata <= '0;
            r_q.ce_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
            r_q.dq_oe <= 1'b0;
            r_q.ack   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    sram_phase_cnt #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load),
        .val_i  (cnt_val),
        .zero_o (cnt_zero)
    );

    sram_rd_latch #(.DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (rd_capture),
        .din_i     (mem_dq_i),
        .rdata_o   (host_rdata_o),
        .rvalid_o  (host_rvalid_o)
    );

    assign host_ack_o  = r_q.ack;
    assign mem_addr_o  = r_q.addr;
    assign mem_ce_n_o  = r_q.ce_n;
    assign mem_oe_n_o  = r_q.oe_n;
    assign mem_we_n_o  = r_q.we_n;
    assign mem_dq_o    = r_q.wdata;
    assign mem_dq_oe_o = r_q.dq_oe;
endmodule

// File: rtl/sram_ctrl_checks.sv
module sram_ctrl_checks #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned RD_MIN = 1,
    parameter int unsigned WP_MIN = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              rvalid,
    input logic [ADDR_W-1:0] addr,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              dq_oe
);
    logic [7:0] we_lo_q, oe_lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_lo_q <= '0;
            oe_lo_q <= '0;
        end else begin
            we_lo_q <= (!we_n) ? ((we_lo_q == 8'hFF) ? we_lo_q : we_lo_q + 8'd1) : 8'd0;
            oe_lo_q <= (!oe_n) ? ((oe_lo_q == 8'hFF) ? oe_lo_q : oe_lo_q + 8'd1) : 8'd0;
        end
    end

    a_r10_no_we_oe_overlap: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !oe_n));
    a_r10_no_drive_on_oe:   assert property (@(posedge clk) disable iff (!rst_n) !(dq_oe && !oe_n));
    a_r5_drive_after_we:    assert property (@(posedge clk) disable iff (!rst_n)
                                $rose(dq_oe) |-> (!we_n && $past(!we_n)));
    a_r4_we_inside_ce:      assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> !ce_n);
    a_r4_we_width:          assert property (@(posedge clk) disable iff (!rst_n)
                                $rose(we_n) |-> (32'(we_lo_q) >= WP_MIN));
    a_r2_oe_width:          assert property (@(posedge clk) disable iff (!rst_n)
                                $rose(oe_n) |-> (32'(oe_lo_q) >= RD_MIN));
    a_r9_addr_stable:       assert property (@(posedge clk) disable iff (!rst_n)
                                (!ce_n && $past(!ce_n)) |-> $stable(addr));
    a_r6_ack_single:        assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);
    a_r3_rvalid_with_ack:   assert property (@(posedge clk) disable iff (!rst_n) rvalid |-> ack);
    a_r8_ce_gap:            assert property (@(posedge clk) disable iff (!rst_n) $rose(ce_n) |=> ce_n);
endmodule

bind sram_async_ctrl sram_ctrl_checks #(
    .ADDR_W (ADDR_W),
    .RD_MIN (RD_CYC),
    .WP_MIN (WP_CYC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ack    (host_ack_o),
    .rvalid (host_rvalid_o),
    .addr   (mem_addr_o),
    .ce_n   (mem_ce_n_o),
    .oe_n   (mem_oe_n_o),
    .we_n   (mem_we_n_o),
    .dq_oe  (mem_dq_oe_o)
);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;
    localparam int CLK_PS = 4000;
    // Expected phase lengths from the requirements: 10 ns access/cycle,
    // 7 ns strobe, 6 ns data setup, 7 ns address setup, 4 ns clock.
    localparam int RD_N = 3;   // ceil(10/4)
    localparam int WP_N = 3;   // max(ceil(7/4)=2, ceil(6/4)+1=3, 2, ceil(10/4)-1=2)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req_i = 1'b0;
    logic        host_we_i = 1'b0;
    logic [18:0] host_addr_i = '0;
    logic [7:0]  host_wdata_i = '0;
    logic        host_ack_o;
    logic [7:0]  host_rdata_o;
    logic        host_rvalid_o;
    logic [18:0] mem_addr_o;
    logic        mem_ce_n_o, mem_oe_n_o, mem_we_n_o;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i = 8'hC3;
    logic        mem_dq_oe_o;

    always #2ns clk = ~clk;

    sram_async_ctrl #(.CLK_PS(CLK_PS)) u_dut (.*);

    int total = 0;
    int bad   = 0;

    typedef struct {
        bit       ce_n, oe_n, we_n, dq_oe, ack, rvalid;
        bit [18:0] addr;
        bit [7:0]  data;
        string     tag;
    } exp_t;

    exp_t q_exp[$];
    bit   last_ack = 1'b0;
    bit   acc_flag = 1'b0;
    logic [7:0] smem [int];   // memory stub contents
    logic [7:0] emem [int];   // bench expectation

    function automatic logic [7:0] blank(input int a);
        return 8'h5A ^ a[7:0] ^ a[15:8];
    endfunction

    function automatic exp_t mk(bit ce, bit oe, bit we, bit dqe, bit ak, bit rv,
                                bit [18:0] a, bit [7:0] d, string t);
        exp_t e;
        e.ce_n = ce; e.oe_n = oe; e.we_n = we; e.dq_oe = dqe;
        e.ack = ak; e.rvalid = rv; e.addr = a; e.data = d; e.tag = t;
        return e;
    endfunction

    task automatic fail(string req, string what, int act, int expv);
        bad++;
        $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    endtask

    // Reference model and per-cycle comparison.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (q_exp.size() > 0) e = q_exp.pop_front();
            else e = mk(1, 1, 1, 0, 0, 0, '0, '0, "R1/R7 idle");
            total++;
            if (mem_ce_n_o !== e.ce_n)  fail(e.tag, "ce_n", mem_ce_n_o, e.ce_n);
            else if (mem_oe_n_o !== e.oe_n)  fail(e.tag, "oe_n", mem_oe_n_o, e.oe_n);
            else if (mem_we_n_o !== e.we_n)  fail(e.tag, "we_n", mem_we_n_o, e.we_n);
            else if (mem_dq_oe_o !== e.dq_oe) fail("R5", "dq_oe", mem_dq_oe_o, e.dq_oe);
            else if (host_ack_o !== e.ack) fail("R3/R6 ack", e.tag, host_ack_o, e.ack);
            else if (host_rvalid_o !== e.rvalid) fail("R3 rvalid", e.tag, host_rvalid_o, e.rvalid);
            else if (!e.ce_n && mem_addr_o !== e.addr) fail("R9 addr", e.tag, mem_addr_o, e.addr);
            else if (e.dq_oe && mem_dq_o !== e.data) fail("R5 dq_o", e.tag, mem_dq_o, e.data);
            else if (e.rvalid && host_rdata_o !== e.data) fail("R3 rdata", e.tag, host_rdata_o, e.data);
            last_ack = e.ack;
            if (q_exp.size() == 0 && !last_ack && host_req_i) begin
                int a;
                a = int'(host_addr_i);
                acc_flag = 1'b1;
                if (host_we_i) begin
                    q_exp.push_back(mk(0, 1, 1, 0, 0, 0, host_addr_i, host_wdata_i, "R4 setup"));
                    for (int i = 0; i < WP_N; i++)
                        q_exp.push_back(mk(0, 1, 0, (i > 0), 0, 0, host_addr_i, host_wdata_i, "R4 pulse"));
                    q_exp.push_back(mk(1, 1, 1, 1, 1, 0, host_addr_i, host_wdata_i, "R6 end"));
                    emem[a] = host_wdata_i;
                end else begin
                    logic [7:0] v;
                    v = emem.exists(a) ? emem[a] : blank(a);
                    for (int i = 0; i < RD_N; i++)
                        q_exp.push_back(mk(0, 0, 1, 0, 0, 0, host_addr_i, v, "R2 read"));
                    q_exp.push_back(mk(1, 1, 1, 0, 1, 1, host_addr_i, v, "R3 done"));
                end
            end
        end
    end

    // Cycle-accurate memory stub with timing counters.
    int rd_lo = 0, wlo = 0, dlo = 0;
    logic [7:0]  wbyte;
    logic [18:0] waddr;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe_o && !mem_oe_n_o) fail("R10", "bus contention", 1, 0);
            if (!mem_we_n_o && !mem_oe_n_o) fail("R10", "we/oe overlap", 1, 0);
            if (!mem_ce_n_o && !mem_oe_n_o && mem_we_n_o) begin
                int a;
                a = int'(mem_addr_o);
                rd_lo++;
                if (rd_lo >= RD_N) mem_dq_i = smem.exists(a) ? smem[a] : blank(a);
                else mem_dq_i = 8'hC3;
            end else begin
                rd_lo = 0;
                mem_dq_i = 8'hC3;
            end
            if (!mem_ce_n_o && !mem_we_n_o) begin
                if (wlo > 0 && mem_addr_o !== waddr) fail("R9", "addr moved in write", mem_addr_o, waddr);
                waddr = mem_addr_o;
                wlo++;
                if (mem_dq_oe_o) begin dlo++; wbyte = mem_dq_o; end
            end else if (wlo > 0) begin
                total++;
                if (wlo < WP_N) fail("R4", "strobe width", wlo, WP_N);
                else if (dlo < WP_N - 1) fail("R5", "data setup", dlo, WP_N - 1);
                smem[int'(waddr)] = wbyte;
                wlo = 0; dlo = 0;
            end
        end
    end

    task automatic wait_accept();
        do begin @(posedge clk); #1ns; end while (!acc_flag);
        acc_flag = 1'b0;
    endtask

    task automatic wait_ack();
        while (!host_ack_o) begin @(posedge clk); #1ns; end
    endtask

    task automatic access(bit we, logic [18:0] a, logic [7:0] d);
        @(posedge clk); #1ns;
        host_req_i = 1'b1; host_we_i = we; host_addr_i = a; host_wdata_i = d;
        wait_accept();
        host_req_i = 1'b0;                      // R9: scramble fields after acceptance
        host_addr_i = ~a; host_wdata_i = ~d; host_we_i = ~we;
        wait_ack();
        if (!we) begin
            total++;
            if (host_rdata_o !== (emem.exists(int'(a)) ? emem[int'(a)] : blank(int'(a))))
                fail("R3", "readback", host_rdata_o, emem.exists(int'(a)) ? emem[int'(a)] : blank(int'(a)));
        end
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        total++;   // R1 reset state, sampled while reset is held
        if ({mem_ce_n_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o, host_ack_o, host_rvalid_o} !== 6'b111000)
            fail("R1", "reset pins",
                 {mem_ce_n_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o, host_ack_o, host_rvalid_o}, 6'b111000);
        @(posedge clk); #1ns; rst_n = 1'b1;
        repeat (3) @(posedge clk);

        access(1, 19'h00000, 8'h00);
        access(1, 19'h7FFFF, 8'hFF);
        access(1, 19'h12345, 8'hA5);
        access(0, 19'h7FFFF, 8'h00);
        access(0, 19'h00000, 8'h00);
        access(0, 19'h12345, 8'h00);
        access(0, 19'h0BEEF, 8'h00);     // never written
        access(1, 19'h12345, 8'h3C);     // overwrite
        access(0, 19'h12345, 8'h00);

        // R7/R8: request held through the ack, new fields presented at once.
        @(posedge clk); #1ns;
        host_req_i = 1'b1; host_we_i = 1'b1; host_addr_i = 19'h2AAAA; host_wdata_i = 8'h96;
        wait_accept();
        host_we_i = 1'b0; host_wdata_i = 8'h11;   // next request: read same place
        wait_ack();
        wait_accept();
        host_req_i = 1'b0;
        wait_ack();
        total++;
        if (host_rdata_o !== 8'h96) fail("R7", "back-to-back readback", host_rdata_o, 8'h96);

        // Read then write held back-to-back (turnaround).
        @(posedge clk); #1ns;
        host_req_i = 1'b1; host_we_i = 1'b0; host_addr_i = 19'h00000;
        wait_accept();
        host_we_i = 1'b1; host_addr_i = 19'h00001; host_wdata_i = 8'h7E;
        wait_ack();
        wait_accept();
        host_req_i = 1'b0;
        wait_ack();
        access(0, 19'h00001, 8'h00);

        repeat (6) @(posedge clk);
        total++;   // R1 idle after traffic
        if ({mem_ce_n_o, mem_dq_oe_o} !== 2'b10) fail("R1", "idle pins", {mem_ce_n_o, mem_dq_oe_o}, 2'b10);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule